// File: doc/BRIEF.md
# Second-Level Cache Flush and Clean Sequencer

This block performs maintenance of the whole second-level cache on a software command. Two command registers sit behind a small register port: one starts a flush and the other starts a clean. A command bit works as a busy flag. Software sets it, the block holds it at 1 while it walks the cache, and the block clears it to 0 when the walk is complete.

During a walk the sequencer reads every second-level line in turn through a line-walk port. A line that is not valid is skipped. For a valid line, the sequencer first snoops the first-level data cache. If the data cache holds a modified copy, that copy replaces the stale second-level data. The line is then sent to a DMA write channel that leads to external memory. A clean does more after the DMA channel accepts the line. It asks the program cache to invalidate the line and waits for the acknowledge. It then invalidates the second-level line. The data-cache copy is dropped by the snoop itself, which carries an invalidate flag during a clean.

Top module: `l2_maint_seq`

## Requirements
- R1: Writing a value with bit 0 set to register address 0 (flush) starts a flush when no operation is busy. Bit 0 of that register reads 1 from the cycle after the write until the walk ends, and reads 0 after that.
- R2: Writing a value with bit 0 set to register address 1 (clean) starts a clean in the same way, with the same busy-flag behaviour on bit 0 of that register. All other read bits are 0.
- R3: Writing a value with bit 0 clear to either register has no effect: no line is read and both registers keep reading 0.
- R4: Any command write while an operation is busy is ignored. The other register stays 0, and the running walk is not restarted. At most one operation is busy at a time.
- R5: Each operation reads every line index exactly once, in ascending order from 0 to 2^IDX_W-1.
- R6: A line reported invalid causes no snoop, no DMA request and no invalidation.
- R7: Every valid line is snooped before it is copied. The snoop address is {tag, index}. The snoop invalidate flag is 0 for a flush and 1 for a clean. The request is held until it is acknowledged.
- R8: The DMA request carries the line address {tag, index}. Its data is the snoop data when the snoop reports the line modified, and the second-level data otherwise.
- R9: A clean issues a program-cache invalidate with the line address and then a one-cycle second-level invalidate at the line index, for every copied line. A flush issues neither. After a clean, a following flush copies nothing.
- R10: A DMA or invalidate request is held stable until it is acknowledged. The next line read starts only after every request for the current line has completed, so at most one request is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 flush, 1 clean |
| reg_wdata | input | REG_W | Write data; bit 0 is the command bit |
| reg_rdata | output | REG_W | Read data for reg_addr; bit 0 is the busy flag |
| ln_rd | output | 1 | Line read strobe; the array answers in the next cycle |
| ln_inv | output | 1 | One-cycle second-level invalidate at ln_idx |
| ln_idx | output | IDX_W | Line index being walked |
| ln_valid | input | 1 | Valid bit of the line that was read |
| ln_tag | input | TAG_W | Tag of the line that was read |
| ln_data | input | LINE_W | Data of the line that was read |
| snp_req | output | 1 | Data-cache snoop request |
| snp_inv | output | 1 | Snoop also invalidates the data-cache line |
| snp_addr | output | TAG_W+IDX_W | Snooped line address |
| snp_ack | input | 1 | Snoop response strobe |
| snp_dirty | input | 1 | The data cache held a modified copy |
| snp_data | input | LINE_W | Modified data from the data cache |
| pc_inv_req | output | 1 | Program-cache invalidate request |
| pc_inv_addr | output | TAG_W+IDX_W | Line address to invalidate |
| pc_inv_ack | input | 1 | Program-cache invalidate done |
| dma_req | output | 1 | DMA write request |
| dma_addr | output | TAG_W+IDX_W | External line address |
| dma_data | output | LINE_W | Line data to write |
| dma_ack | input | 1 | DMA channel accepted the request |

## Verification
A corrupted line index shows up at the very next read strobe as an out-of-order index, or at the end of the walk as a wrong read count. A wrong data choice or latched tag shows up at the DMA accept of that same line, because the scoreboard compares each accepted request with the line it predicted. If a busy flag is stuck or cleared early, the next register read shows it. If a request is dropped before its acknowledge, the bench sees it within a few cycles as a read strobe or a second request that overlaps a pending one.

// File: rtl/l2m_pkg.sv
package l2m_pkg;

  localparam logic REG_SEL_FLUSH = 1'b0;
  localparam logic REG_SEL_CLEAN = 1'b1;
  localparam int   CMD_BIT       = 0;

  typedef enum logic {
    OP_FLUSH = 1'b0,
    OP_CLEAN = 1'b1
  } maint_op_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_RD,
    W_CHK,
    W_SNP,
    W_DMA,
    W_PINV,
    W_LINV,
    W_NEXT
  } walk_st_e;

endpackage

// File: rtl/l2m_ctrl_regs.sv
module l2m_ctrl_regs
  import l2m_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             walk_done,
  output logic             start_go,
  output maint_op_e        start_op,
  output logic             flush_busy,
  output logic             clean_busy
);

  logic any_busy;
  logic cmd_set;

  assign any_busy = flush_busy | clean_busy;
  assign cmd_set  = reg_we & reg_wdata[CMD_BIT];
  assign start_go = cmd_set & ~any_busy;
  assign start_op = (reg_addr == REG_SEL_CLEAN) ? OP_CLEAN : OP_FLUSH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_busy <= 1'b0;
      clean_busy <= 1'b0;
    end else if (start_go) begin
      flush_busy <= (start_op == OP_FLUSH);
      clean_busy <= (start_op == OP_CLEAN);
    end else if (walk_done) begin
      flush_busy <= 1'b0;
      clean_busy <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[CMD_BIT] = (reg_addr == REG_SEL_CLEAN) ? clean_busy : flush_busy;
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_busy && clean_busy)); // R4
  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy && !walk_done |=> flush_busy); // R1
  AST_CLEAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clean_busy && !walk_done |=> clean_busy); // R2

endmodule

// File: rtl/l2m_line_walker.sv
module l2m_line_walker
  import l2m_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_go,
  input  maint_op_e              start_op,
  output logic                   walk_done,
  output logic                   ln_rd,
  output logic                   ln_inv,
  output logic [IDX_W-1:0]       ln_idx,
  input  logic                   ln_valid,
  input  logic [TAG_W-1:0]       ln_tag,
  input  logic [LINE_W-1:0]      ln_data,
  output logic                   snp_req,
  output logic                   snp_inv,
  output logic [TAG_W+IDX_W-1:0] snp_addr,
  input  logic                   snp_ack,
  input  logic                   snp_dirty,
  input  logic [LINE_W-1:0]      snp_data,
  output logic                   pc_inv_req,
  output logic [TAG_W+IDX_W-1:0] pc_inv_addr,
  input  logic                   pc_inv_ack,
  output logic                   dma_req,
  output logic [TAG_W+IDX_W-1:0] dma_addr,
  output logic [LINE_W-1:0]      dma_data,
  input  logic                   dma_ack
);

  localparam int ADDR_W = TAG_W + IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] tag,
                                                  input logic [IDX_W-1:0] idx);
    return {tag, idx};
  endfunction

  function automatic logic [LINE_W-1:0] pick_data(input logic dirty,
                                                  input logic [LINE_W-1:0] from_l1,
                                                  input logic [LINE_W-1:0] from_l2);
    return dirty ? from_l1 : from_l2;
  endfunction

  walk_st_e          st;
  maint_op_e         op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] data_q;

  logic line_take;
  logic line_skip;
  logic snp_done;
  logic dma_done;
  logic pinv_done;
  logic last_line;

  assign line_take = (st == W_CHK) &&  ln_valid;
  assign line_skip = (st == W_CHK) && !ln_valid;
  assign snp_done  = (st == W_SNP) && snp_ack;
  assign dma_done  = (st == W_DMA) && dma_ack;
  assign pinv_done = (st == W_PINV) && pc_inv_ack;
  assign last_line = (idx_q == LAST_IDX);
  assign walk_done = (st == W_NEXT) && last_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      op_q   <= OP_FLUSH;
      idx_q  <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      case (st)
        W_IDLE: if (start_go) begin
          op_q  <= start_op;
          idx_q <= '0;
          st    <= W_RD;
        end
        W_RD: st <= W_CHK;
        W_CHK: begin
          if (line_take) begin
            tag_q  <= ln_tag;
            data_q <= ln_data;
            st     <= W_SNP;
          end else begin
            st <= W_NEXT;
          end
        end
        W_SNP: if (snp_done) begin
          data_q <= pick_data(snp_dirty, snp_data, data_q);
          st     <= W_DMA;
        end
        W_DMA: if (dma_done) begin
          st <= (op_q == OP_CLEAN) ? W_PINV : W_NEXT;
        end
        W_PINV: if (pinv_done) st <= W_LINV;
        W_LINV: st <= W_NEXT;
        W_NEXT: begin
          if (last_line) begin
            st <= W_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= W_RD;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign ln_rd       = (st == W_RD);
  assign ln_inv      = (st == W_LINV);
  assign ln_idx      = idx_q;
  assign snp_req     = (st == W_SNP);
  assign snp_inv     = (op_q == OP_CLEAN);
  assign snp_addr    = line_addr(tag_q, idx_q);
  assign dma_req     = (st == W_DMA);
  assign dma_addr    = line_addr(tag_q, idx_q);
  assign dma_data    = data_q;
  assign pc_inv_req  = (st == W_PINV);
  assign pc_inv_addr = line_addr(tag_q, idx_q);

  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req && $stable(dma_addr) && $stable(dma_data)); // R10
  AST_PINV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inv_req && !pc_inv_ack |=> pc_inv_req && $stable(pc_inv_addr)); // R10
  AST_SNP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    snp_req && !snp_ack |=> snp_req && $stable(snp_addr)); // R7
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ln_rd, snp_req, dma_req, pc_inv_req, ln_inv})); // R10
  AST_FLUSH_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    op_q == OP_FLUSH |-> !pc_inv_req && !ln_inv); // R9
  AST_SKIP_NO_SNP: assert property (@(posedge clk) disable iff (!rst_n)
    line_skip |=> !snp_req && !dma_req); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ln_rd && $past(st) == W_NEXT |-> ln_idx == $past(ln_idx) + 1'b1); // R5

endmodule

// File: rtl/l2_maint_seq.sv
module l2_maint_seq
  import l2m_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic                   reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic                   ln_rd,
  output logic                   ln_inv,
  output logic [IDX_W-1:0]       ln_idx,
  input  logic                   ln_valid,
  input  logic [TAG_W-1:0]       ln_tag,
  input  logic [LINE_W-1:0]      ln_data,
  output logic                   snp_req,
  output logic                   snp_inv,
  output logic [TAG_W+IDX_W-1:0] snp_addr,
  input  logic                   snp_ack,
  input  logic                   snp_dirty,
  input  logic [LINE_W-1:0]      snp_data,
  output logic                   pc_inv_req,
  output logic [TAG_W+IDX_W-1:0] pc_inv_addr,
  input  logic                   pc_inv_ack,
  output logic                   dma_req,
  output logic [TAG_W+IDX_W-1:0] dma_addr,
  output logic [LINE_W-1:0]      dma_data,
  input  logic                   dma_ack
);

  logic      start_go;
  maint_op_e start_op;
  logic      walk_done;
  logic      flush_busy;
  logic      clean_busy;

  l2m_ctrl_regs #(.REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .walk_done  (walk_done),
    .start_go   (start_go),
    .start_op   (start_op),
    .flush_busy (flush_busy),
    .clean_busy (clean_busy)
  );

  l2m_line_walker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_go    (start_go),
    .start_op    (start_op),
    .walk_done   (walk_done),
    .ln_rd       (ln_rd),
    .ln_inv      (ln_inv),
    .ln_idx      (ln_idx),
    .ln_valid    (ln_valid),
    .ln_tag      (ln_tag),
    .ln_data     (ln_data),
    .snp_req     (snp_req),
    .snp_inv     (snp_inv),
    .snp_addr    (snp_addr),
    .snp_ack     (snp_ack),
    .snp_dirty   (snp_dirty),
    .snp_data    (snp_data),
    .pc_inv_req  (pc_inv_req),
    .pc_inv_addr (pc_inv_addr),
    .pc_inv_ack  (pc_inv_ack),
    .dma_req     (dma_req),
    .dma_addr    (dma_addr),
    .dma_data    (dma_data),
    .dma_ack     (dma_ack)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_busy || clean_busy) |-> !ln_rd && !dma_req && !snp_req); // R3
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> flush_busy || clean_busy); // R1

endmodule

// File: tb/tb_l2_maint_seq.sv
module tb_l2_maint_seq;
  localparam int REG_W = 32, IDX_W = 4, TAG_W = 8, LINE_W = 32;
  localparam int N = 1 << IDX_W;
  localparam int AW = TAG_W + IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic reg_we = 0, reg_addr = 0;
  logic [REG_W-1:0] reg_wdata = '0, reg_rdata;
  logic ln_rd, ln_inv, ln_valid;
  logic [IDX_W-1:0] ln_idx;
  logic [TAG_W-1:0] ln_tag;
  logic [LINE_W-1:0] ln_data;
  logic snp_req, snp_inv, snp_ack = 0, snp_dirty = 0;
  logic [AW-1:0] snp_addr, pc_inv_addr, dma_addr;
  logic [LINE_W-1:0] snp_data = '0, dma_data;
  logic pc_inv_req, pc_inv_ack = 0, dma_req, dma_ack = 0;

  l2_maint_seq #(.REG_W(REG_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) dut (.*);

  // cache models
  logic              v[N], dty[N];
  logic [TAG_W-1:0]  tg[N];
  logic [LINE_W-1:0] l2d[N], l1d[N];
  logic [IDX_W-1:0]  rd_q = '0;
  assign ln_valid = v[rd_q];
  assign ln_tag   = tg[rd_q];
  assign ln_data  = l2d[rd_q];

  typedef struct { logic [AW-1:0] a; logic [LINE_W-1:0] d; } dma_item_t;
  dma_item_t exp_dma[$];
  logic [AW-1:0] exp_pc[$];
  logic [IDX_W-1:0] exp_li[$];

  int total = 0, bad = 0;
  int rd_cnt, snp_cnt, dma_cnt, pc_cnt, li_cnt, exp_rd;
  logic cur_clean = 0;
  logic [7:0] lcg = 8'h5b;
  int sd = 0, dd = 0, pd = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int next_dly();
    lcg = lcg * 8'd29 + 8'd37;
    return int'(lcg[6:5]) % 3;
  endfunction

  // monitor and responders
  always @(negedge clk) begin
    if (rst_n) begin
      if (ln_rd) begin
        chk(ln_idx == exp_rd[IDX_W-1:0], "R5 index order", ln_idx, exp_rd);
        chk(!(snp_req || dma_req || pc_inv_req), "R10 read overlaps request", 1, 0);
        rd_q = ln_idx; exp_rd++; rd_cnt++;
      end
      if (snp_ack) snp_ack = 0;
      else if (snp_req) begin
        if (sd == 0) begin
          automatic int i = int'(snp_addr[IDX_W-1:0]);
          chk(snp_inv == cur_clean, "R7 snoop invalidate flag", snp_inv, cur_clean);
          chk(snp_addr == {tg[i], snp_addr[IDX_W-1:0]}, "R7 snoop address", snp_addr, {tg[i], snp_addr[IDX_W-1:0]});
          snp_ack = 1; snp_dirty = dty[i]; snp_data = l1d[i];
          if (snp_inv) dty[i] = 0;
          snp_cnt++; sd = next_dly();
        end else sd--;
      end
      if (dma_ack) dma_ack = 0;
      else if (dma_req) begin
        if (dd == 0) begin
          dma_cnt++;
          if (exp_dma.size() == 0) chk(0, "R6 unexpected DMA", dma_addr, 0);
          else begin
            automatic dma_item_t e = exp_dma.pop_front();
            chk(dma_addr == e.a, "R8 DMA address", dma_addr, e.a);
            chk(dma_data == e.d, "R8 DMA data", dma_data, e.d);
          end
          dma_ack = 1; dd = next_dly();
        end else dd--;
      end
      if (pc_inv_ack) pc_inv_ack = 0;
      else if (pc_inv_req) begin
        if (pd == 0) begin
          pc_cnt++;
          if (exp_pc.size() == 0) chk(0, "R9 unexpected program invalidate", pc_inv_addr, 0);
          else begin
            automatic logic [AW-1:0] e = exp_pc.pop_front();
            chk(pc_inv_addr == e, "R9 program invalidate address", pc_inv_addr, e);
          end
          pc_inv_ack = 1; pd = next_dly();
        end else pd--;
      end
      if (ln_inv) begin
        li_cnt++;
        if (exp_li.size() == 0) chk(0, "R9 unexpected L2 invalidate", ln_idx, 0);
        else begin
          automatic logic [IDX_W-1:0] e = exp_li.pop_front();
          chk(ln_idx == e, "R9 L2 invalidate index", ln_idx, e);
        end
        v[ln_idx] = 0;
      end
    end
  end

  task automatic wr(input logic a, input logic [REG_W-1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [REG_W-1:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic int nvalid();
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic run_op(input logic clean, input bit interfere);
    logic [REG_W-1:0] r;
    int nv = nvalid();
    rd_cnt = 0; snp_cnt = 0; dma_cnt = 0; pc_cnt = 0; li_cnt = 0; exp_rd = 0;
    cur_clean = clean;
    for (int i = 0; i < N; i++) if (v[i]) begin
      automatic dma_item_t e;
      e.a = {tg[i], i[IDX_W-1:0]};
      e.d = dty[i] ? l1d[i] : l2d[i];
      exp_dma.push_back(e);
      if (clean) begin exp_pc.push_back(e.a); exp_li.push_back(i[IDX_W-1:0]); end
    end
    wr(clean, 32'h1);
    rd(clean, r);
    chk(r == 32'h1, clean ? "R2 busy after start" : "R1 busy after start", r, 1);
    rd(!clean, r);
    chk(r == 32'h0, "R4 other register idle", r, 0);
    if (interfere) begin
      wr(!clean, 32'h1);
      rd(!clean, r);
      chk(r == 32'h0, "R4 second command ignored", r, 0);
      wr(clean, 32'h1);
    end
    do rd(clean, r); while (r[0] == 1'b1);
    chk(r == 32'h0, clean ? "R2 cleared at end" : "R1 cleared at end", r, 0);
    repeat (3) @(negedge clk);
    chk(rd_cnt == N, "R5 every line read once", rd_cnt, N);
    chk(snp_cnt == nv, "R6 snoops only valid lines", snp_cnt, nv);
    chk(dma_cnt == nv, "R6 DMA only valid lines", dma_cnt, nv);
    chk(exp_dma.size() == 0, "R8 all expected lines copied", exp_dma.size(), 0);
    chk(pc_cnt == (clean ? nv : 0), "R9 program invalidate count", pc_cnt, clean ? nv : 0);
    chk(li_cnt == (clean ? nv : 0), "R9 L2 invalidate count", li_cnt, clean ? nv : 0);
    exp_pc.delete(); exp_li.delete(); exp_dma.delete();
  endtask

  initial begin
    logic [REG_W-1:0] r;
    for (int i = 0; i < N; i++) begin
      v[i] = 0; dty[i] = 0; tg[i] = '0; l2d[i] = '0; l1d[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(1'b0, r); chk(r == 0, "R1 reset flush reg", r, 0);
    rd(1'b1, r); chk(r == 0, "R2 reset clean reg", r, 0);
    chk(!dma_req && !snp_req && !ln_rd, "R10 reset quiet", dma_req, 0);

    rd_cnt = 0;
    wr(1'b0, 32'hFFFF_FFFE); wr(1'b1, 32'h0000_0002);
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0, "R3 zero write starts nothing", rd_cnt, 0);
    rd(1'b0, r); chk(r == 0, "R3 flush reg stays 0", r, 0);
    rd(1'b1, r); chk(r == 0, "R3 clean reg stays 0", r, 0);

    for (int i = 0; i < N; i++) begin
      v[i] = (i % 3) != 0; dty[i] = (i % 4) == 1;
      tg[i] = 8'(i * 7 + 3); l2d[i] = 32'hA000_0000 + i; l1d[i] = 32'h5D00_0000 + i;
    end
    run_op(1'b0, 1'b1);   // flush with ignored writes
    run_op(1'b1, 1'b1);   // clean of the same contents
    run_op(1'b0, 1'b0);   // R9: nothing left to copy
    chk(dma_cnt == 0, "R9 flush after clean copies nothing", dma_cnt, 0);

    for (int i = 0; i < N; i++) begin v[i] = 0; dty[i] = 1; end
    run_op(1'b1, 1'b0);   // R6: all lines invalid

    for (int i = 0; i < N; i++) begin
      v[i] = 1; dty[i] = 1; tg[i] = 8'(255 - i);
      l2d[i] = 32'h1111_0000 + i; l1d[i] = 32'hC0DE_0000 + i;
    end
    run_op(1'b0, 1'b0);   // R8: modified data from snoop everywhere

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule